// File: doc/BRIEF.md
# Multi-PHY ATM Cell Transmit Port

This block is the PHY-side receiver of a multi-PHY ATM cell transmit bus. An ATM-layer master polls several PHY ports by driving a 5-bit address. The port whose address was on the bus in one cycle answers in the next cycle with a cell-available flag. The master then selects a port by pulling the active-low enable low. While selected, the port takes one 8-bit byte per enabled cycle. Each byte comes with a start-of-cell mark and an odd parity bit.

Accepted cells are 53 bytes long. The port packs them into 16-bit words, 27 words per cell, and stores them in a cell FIFO that holds 243 words. A downstream cell processor drains the FIFO through a simple valid/read port. Words of a cell become visible only when the whole cell has arrived. A cell cut short by a new start-of-cell, or by a full FIFO, is discarded as a unit.

Two flow-control outputs are derived from the free space in the FIFO, each with its own threshold register: cell-available and back-pressure. A one-bit select picks the register for each configuration write. For single-PHY use, the master holds the address lines at this port's address.

Top module: `ctx_txport`

## Requirements
- R1: `tx_clav` in a cycle reflects the address sampled at the previous rising edge. It is 0 when that address is not `PORT_ADDR`, and it is always 0 for the idle address 5'b11111.
- R2: When polled, `tx_clav` is 1 exactly when the free FIFO space in words is at least the cell-available threshold. This threshold is written with `cfg_sel`=0 and resets to 27.
- R3: The FIFO never holds more than 243 words. A byte whose word would not fit discards the whole cell in progress, and the bytes that follow it are ignored until the next start-of-cell.
- R4: The port becomes selected at an edge where the enable is low after being high in the previous cycle, if the address sampled one edge earlier matched. It stays selected or unselected until the next such falling edge. Bytes sent while it is not selected have no effect.
- R5: With the address held at `PORT_ADDR`, every burst of enabled cycles is accepted.
- R6: The first byte of a cell goes in bits [15:8] and the second in [7:0], and so on. Byte 53 fills bits [15:8] of word 27, whose bits [7:0] are 0. No word of a cell is readable before its last byte has been accepted.
- R7: A start-of-cell arriving while a cell is in progress discards the partial cell and starts a new one.
- R8: A byte with no start-of-cell mark, arriving while no cell is in progress, is ignored.
- R9: `tx_parity` is odd parity over `tx_data`. A mismatch on an accepted byte sets `parity_err`, which stays set until reset, and the byte is still stored.
- R10: `tx_bp` is 1 exactly when the free space is below the back-pressure threshold. This threshold is written with `cfg_sel`=1 and resets to 40. Bytes that arrive while `tx_bp` is 1 are still accepted.
- R11: After reset the FIFO is empty, and `tx_clav`, `tx_bp`, `parity_err` and `word_valid` are all 0.
- R12: `word_valid` is 1 while at least one whole-cell word is stored. `word_data` shows the oldest such word, and `word_rd` removes it, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tx_addr | input | 5 | Poll/select address from the master |
| tx_enb_n | input | 1 | Byte enable, active low |
| tx_soc | input | 1 | Start-of-cell mark on the first byte |
| tx_data | input | 8 | Cell byte |
| tx_parity | input | 1 | Odd parity over tx_data |
| tx_clav | output | 1 | Cell-available answer to the previous cycle's poll |
| tx_bp | output | 1 | Back-pressure flag |
| parity_err | output | 1 | Sticky parity error flag |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_sel | input | 1 | 0 selects the cell-available threshold, 1 the back-pressure threshold |
| cfg_wdata | input | 8 | Threshold value in words of free space |
| word_rd | input | 1 | Removes the word shown on word_data |
| word_valid | output | 1 | A whole-cell word is available |
| word_data | output | 16 | Oldest stored word |

## Verification
The bench goes after the cell boundaries. If a start-of-cell cut a cell short, a design that rewound wrongly would leak stale half-cell words into the output stream. A design that committed too early would show `word_valid` before byte 53. The ninth cell fills the FIFO exactly and the tenth must vanish completely; an off-by-one in the full test would either corrupt the last stored word or let a truncated cell through. Selection is tested by changing the address in the middle of a burst, and by a burst after a poll of another port. A design that re-evaluated the address every cycle would lose bytes in the first case and accept foreign cells in the second.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int CELL_WORDS = (CELL_BYTES + 1) / 2;
    localparam int LAST_IDX   = CELL_BYTES - 1;

    typedef struct packed {
        logic [7:0] data;
        logic       soc;
        logic       par;
    } byte_in_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_WORD = 2'd1,
        WR_LAST = 2'd2
    } wr_kind_t;

    typedef struct packed {
        wr_kind_t    kind;
        logic        abort;
        logic [15:0] word;
    } pack_op_t;

    function automatic logic odd_parity_ok(input logic [7:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/ctx_poll.sv
module ctx_poll #(
    parameter int          ADDR_W    = 5,
    parameter logic [4:0]  PORT_ADDR = 5'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic              tx_enb_n,
    input  logic              clav_level,
    output logic              tx_clav,
    output logic              xfer
);
    localparam logic [ADDR_W-1:0] IDLE_ADDR = '1;

    logic hit;
    logic hit_q;
    logic enb_n_q;
    logic sel_q;
    logic start;
    logic sel_now;

    assign hit     = (tx_addr == ADDR_W'(PORT_ADDR)) && (tx_addr != IDLE_ADDR);
    assign start   = enb_n_q && !tx_enb_n;
    assign sel_now = start ? hit_q : sel_q;
    assign xfer    = !tx_enb_n && sel_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            enb_n_q <= 1'b1;
            sel_q   <= 1'b0;
            tx_clav <= 1'b0;
        end else begin
            hit_q   <= hit;
            enb_n_q <= tx_enb_n;
            tx_clav <= hit && clav_level;
            if (start) begin
                sel_q <= hit_q;
            end
        end
    end

endmodule

// File: rtl/ctx_pack.sv
module ctx_pack
    import ctx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     xfer,
    input  byte_in_t din,
    input  logic     full,
    output pack_op_t op,
    output logic     parity_err
);
    logic       in_cell;
    logic [5:0] idx;
    logic [7:0] hold;
    logic       want_wr;

    always_comb begin
        op      = '0;
        want_wr = 1'b0;
        if (xfer) begin
            if (din.soc) begin
                op.abort = in_cell;
            end else if (in_cell) begin
                if (idx[0]) begin
                    want_wr = 1'b1;
                    op.kind = WR_WORD;
                    op.word = {hold, din.data};
                end else if (idx == 6'(LAST_IDX)) begin
                    want_wr = 1'b1;
                    op.kind = WR_LAST;
                    op.word = {din.data, 8'h00};
                end
                if (want_wr && full) begin
                    op.kind  = WR_NONE;
                    op.abort = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cell    <= 1'b0;
            idx        <= '0;
            hold       <= '0;
            parity_err <= 1'b0;
        end else if (xfer) begin
            if (!odd_parity_ok(din.data, din.par)) begin
                parity_err <= 1'b1;
            end
            if (din.soc) begin
                in_cell <= 1'b1;
                idx     <= 6'd1;
                hold    <= din.data;
            end else if (in_cell) begin
                if (op.abort || op.kind == WR_LAST) begin
                    in_cell <= 1'b0;
                end else begin
                    if (!idx[0]) begin
                        hold <= din.data;
                    end
                    idx <= idx + 6'd1;
                end
            end
        end
    end

endmodule

// File: rtl/ctx_fifo.sv
module ctx_fifo
    import ctx_pkg::*;
#(
    parameter int DEPTH = 243,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  pack_op_t      op,
    input  logic          rd,
    output logic          rd_valid,
    output logic [15:0]   rd_data,
    output logic [CW-1:0] occ_com,
    output logic [CW-1:0] pend,
    output logic          full
);
    logic [15:0]   mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] cp;
    logic [AW-1:0] rp;
    logic          do_wr;
    logic          do_rd;
    logic [CW-1:0] occ_nxt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_wr    = (op.kind != WR_NONE) && !op.abort;
    assign rd_valid = (occ_com != '0);
    assign do_rd    = rd && rd_valid;
    assign rd_data  = mem[rp];
    assign full     = ({1'b0, occ_com} + {1'b0, pend}) == (CW + 1)'(DEPTH);

    always_comb begin
        occ_nxt = occ_com;
        if (do_rd) begin
            occ_nxt = occ_nxt - CW'(1);
        end
        if (do_wr && op.kind == WR_LAST) begin
            occ_nxt = occ_nxt + pend + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= op.word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            cp      <= '0;
            rp      <= '0;
            pend    <= '0;
            occ_com <= '0;
        end else begin
            if (op.abort) begin
                wp   <= cp;
                pend <= '0;
            end else if (do_wr) begin
                wp <= step(wp);
                if (op.kind == WR_LAST) begin
                    cp   <= step(wp);
                    pend <= '0;
                end else begin
                    pend <= pend + CW'(1);
                end
            end
            if (do_rd) begin
                rp <= step(rp);
            end
            occ_com <= occ_nxt;
        end
    end

endmodule

// File: rtl/ctx_flags.sv
module ctx_flags #(
    parameter int  CW       = 8,
    parameter int  CLAV_RST = 27,
    parameter int  BP_RST   = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    input  logic [CW-1:0] free,
    output logic          clav_level,
    output logic          bp
);
    logic [CW-1:0] clav_thr;
    logic [CW-1:0] bp_thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            clav_thr <= CW'(CLAV_RST);
            bp_thr   <= CW'(BP_RST);
        end else if (cfg_we) begin
            if (cfg_sel) begin
                bp_thr <= cfg_wdata;
            end else begin
                clav_thr <= cfg_wdata;
            end
        end
    end

    assign clav_level = (free >= clav_thr);
    assign bp         = (free < bp_thr);

endmodule

// File: rtl/ctx_txport.sv
module ctx_txport
    import ctx_pkg::*;
#(
    parameter int         DEPTH     = 243,
    parameter int         ADDR_W    = 5,
    parameter logic [4:0] PORT_ADDR = 5'd3,
    parameter int         CLAV_RST  = 27,
    parameter int         BP_RST    = 40,
    localparam int        CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic              tx_enb_n,
    input  logic              tx_soc,
    input  logic [7:0]        tx_data,
    input  logic              tx_parity,
    output logic              tx_clav,
    output logic              tx_bp,
    output logic              parity_err,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CW-1:0]     cfg_wdata,
    input  logic              word_rd,
    output logic              word_valid,
    output logic [15:0]       word_data
);
    logic          xfer;
    logic          clav_level;
    logic          full;
    byte_in_t      din;
    pack_op_t      op;
    logic [CW-1:0] occ_com;
    logic [CW-1:0] pend;
    logic [CW-1:0] free;

    assign din  = '{data: tx_data, soc: tx_soc, par: tx_parity};
    assign free = CW'(DEPTH) - occ_com - pend;

    ctx_poll #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_poll (
        .clk        (clk),
        .rst        (rst),
        .tx_addr    (tx_addr),
        .tx_enb_n   (tx_enb_n),
        .clav_level (clav_level),
        .tx_clav    (tx_clav),
        .xfer       (xfer)
    );

    ctx_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .xfer       (xfer),
        .din        (din),
        .full       (full),
        .op         (op),
        .parity_err (parity_err)
    );

    ctx_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .rd       (word_rd),
        .rd_valid (word_valid),
        .rd_data  (word_data),
        .occ_com  (occ_com),
        .pend     (pend),
        .full     (full)
    );

    ctx_flags #(
        .CW       (CW),
        .CLAV_RST (CLAV_RST),
        .BP_RST   (BP_RST)
    ) u_flags (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .free       (free),
        .clav_level (clav_level),
        .bp         (tx_bp)
    );

endmodule

// File: rtl/ctx_check.sv
module ctx_check
    import ctx_pkg::*;
#(
    parameter int         DEPTH     = 243,
    parameter int         ADDR_W    = 5,
    parameter logic [4:0] PORT_ADDR = 5'd3,
    localparam int        CW        = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] tx_addr,
    input logic              tx_enb_n,
    input logic              tx_clav,
    input logic              parity_err,
    input logic [CW-1:0]     occ_com,
    input logic [CW-1:0]     pend
);
    assert_clav_other_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_addr != ADDR_W'(PORT_ADDR)) |=> !tx_clav);

    assert_clav_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_addr == '1) |=> !tx_clav);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(occ_com) + int'(pend)) <= DEPTH);

    // R4 / R5: with the enable high nothing can complete a cell
    assert_idle_no_commit_R4: assert property (@(posedge clk) disable iff (rst)
        tx_enb_n |=> (occ_com <= $past(occ_com)));

    assert_pend_bound_R6: assert property (@(posedge clk) disable iff (rst)
        int'(pend) <= CELL_WORDS - 1);

    assert_whole_cell_R6: assert property (@(posedge clk) disable iff (rst)
        (occ_com > $past(occ_com)) |-> (int'(occ_com) - int'($past(occ_com)) >= CELL_WORDS - 1));

    assert_parity_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> parity_err);

endmodule

bind ctx_txport ctx_check #(
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
) u_check (
    .clk        (clk),
    .rst        (rst),
    .tx_addr    (tx_addr),
    .tx_enb_n   (tx_enb_n),
    .tx_clav    (tx_clav),
    .parity_err (parity_err),
    .occ_com    (occ_com),
    .pend       (pend)
);

// File: tb/ctx_txport_test.sv
`timescale 1ns/1ps
module ctx_txport_test;
    localparam int         DEPTH = 243;
    localparam logic [4:0] PORT  = 5'd3;
    localparam logic [4:0] OTHER = 5'd9;
    localparam logic [4:0] IDLE  = 5'h1F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  tx_addr = IDLE;
    logic        tx_enb_n = 1'b1;
    logic        tx_soc = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_parity = 1'b1;
    logic        tx_clav, tx_bp, parity_err;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        word_rd = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_com[$];
    logic [15:0] m_pend[$];
    bit          m_in = 0;
    int          m_idx = 0;
    logic [7:0]  m_hold;

    always #2 clk = ~clk;

    ctx_txport #(.DEPTH(DEPTH), .PORT_ADDR(PORT)) uut (
        .clk(clk), .rst(rst), .tx_addr(tx_addr), .tx_enb_n(tx_enb_n),
        .tx_soc(tx_soc), .tx_data(tx_data), .tx_parity(tx_parity),
        .tx_clav(tx_clav), .tx_bp(tx_bp), .parity_err(parity_err),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .word_rd(word_rd), .word_valid(word_valid), .word_data(word_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit mdl_push(input logic [15:0] w);
        if (m_com.size() + m_pend.size() >= DEPTH) begin
            m_pend.delete();
            m_in = 0;
            return 0;
        end
        m_pend.push_back(w);
        return 1;
    endfunction

    // expected behaviour per R3, R6, R7, R8
    function automatic void mdl_byte(input logic [7:0] d, input bit soc);
        if (soc) begin
            m_pend.delete();
            m_in = 1; m_idx = 1; m_hold = d;
            return;
        end
        if (!m_in) return;
        if (m_idx % 2 == 1) begin
            if (mdl_push({m_hold, d})) m_idx++;
        end else if (m_idx == 52) begin
            if (mdl_push({d, 8'h00})) begin
                while (m_pend.size() > 0) m_com.push_back(m_pend.pop_front());
                m_in = 0;
            end
        end else begin
            m_hold = d;
            m_idx++;
        end
    endfunction

    task automatic poll(input logic [4:0] a);
        @(negedge clk);
        tx_addr = a; tx_enb_n = 1'b1; tx_soc = 1'b0;
    endtask

    task automatic poll_chk(input bit exp, input string req);
        poll(PORT);
        @(negedge clk);
        chk(tx_clav == exp, req, tx_clav, exp);
    endtask

    task automatic send_bytes(input int n, input bit first_soc, input bit modl,
                              input logic [4:0] a, input int bad_at);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'($urandom_range(0, 255));
            @(negedge clk);
            tx_addr = a; tx_enb_n = 1'b0;
            tx_soc = (i == 0) && first_soc;
            tx_data = d;
            tx_parity = ~(^d) ^ (i == bad_at);
            if (modl) mdl_byte(d, tx_soc);
        end
    endtask

    task automatic cfg(input bit sel, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain(input string req, input int exp_n);
        int got = 0;
        forever begin
            @(negedge clk);
            if (!word_valid) begin word_rd = 1'b0; break; end
            if (m_com.size() == 0) begin
                chk(0, req, word_data, -1); word_rd = 1'b0; break;
            end
            begin
                logic [15:0] e;
                e = m_com.pop_front();
                chk(word_data == e, req, word_data, e);
            end
            word_rd = 1'b1;
            got++;
        end
        if (exp_n >= 0) chk(got == exp_n, req, got, exp_n);
        chk(m_com.size() == 0, req, m_com.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(tx_clav == 0, "R11 clav", tx_clav, 0);
        chk(tx_bp == 0, "R11 bp", tx_bp, 0);
        chk(parity_err == 0, "R11 perr", parity_err, 0);
        chk(word_valid == 0, "R11 valid", word_valid, 0);

        // R1 polling response one cycle late
        poll_chk(1, "R1 own addr");
        poll(IDLE); @(negedge clk); chk(tx_clav == 0, "R1 idle addr", tx_clav, 0);
        poll(OTHER); @(negedge clk); chk(tx_clav == 0, "R1 other addr", tx_clav, 0);

        // R6/R12 one cell, address moves during burst (R4 stays selected)
        poll(PORT);
        send_bytes(52, 1, 1, OTHER, -1);
        @(negedge clk);
        chk(word_valid == 0, "R6 no word before last byte", word_valid, 0);
        tx_enb_n = 1'b1; tx_addr = PORT;
        send_bytes(1, 0, 1, OTHER, -1);
        poll(OTHER);
        drain("R6 R12 packing", 27);

        // R4 burst after a poll of another port is ignored
        poll(OTHER);
        send_bytes(53, 1, 0, PORT, -1);
        poll(OTHER);
        @(negedge clk);
        chk(word_valid == 0, "R4 unselected ignored", word_valid, 0);

        // R8 bytes without start-of-cell
        poll(PORT);
        send_bytes(10, 0, 1, PORT, -1);
        poll(OTHER);
        @(negedge clk);
        chk(word_valid == 0, "R8 stray bytes ignored", word_valid, 0);

        // R7 partial cell cut by new start-of-cell
        poll(PORT);
        send_bytes(20, 1, 1, OTHER, -1);
        send_bytes(53, 1, 1, OTHER, -1);
        poll(OTHER);
        drain("R7 partial discarded", 27);

        // R9 parity
        chk(parity_err == 0, "R9 no error yet", parity_err, 0);
        poll(PORT);
        send_bytes(53, 1, 1, OTHER, 5);
        poll(OTHER);
        @(negedge clk);
        chk(parity_err == 1, "R9 error set", parity_err, 1);
        drain("R9 byte still stored", 27);
        chk(parity_err == 1, "R9 sticky", parity_err, 1);

        // R2 / R10 thresholds
        cfg(0, 243);
        cfg(1, 230);
        poll_chk(1, "R2 empty meets 243");
        chk(tx_bp == 0, "R10 bp low", tx_bp, 0);
        send_bytes(53, 1, 1, OTHER, -1);
        poll_chk(0, "R2 free 216 below 243");
        chk(tx_bp == 1, "R10 bp high", tx_bp, 1);
        send_bytes(53, 1, 1, OTHER, -1);
        poll(OTHER);
        drain("R10 accepted under bp", 54);
        chk(tx_bp == 0, "R10 bp released", tx_bp, 0);
        cfg(0, 27);
        cfg(1, 40);

        // R3 fill exactly, then overflow cell vanishes
        for (int c = 0; c < 9; c++) begin
            poll(PORT);
            send_bytes(53, 1, 1, OTHER, -1);
        end
        poll_chk(0, "R3 R2 full no clav");
        chk(tx_bp == 1, "R3 R10 full bp", tx_bp, 1);
        send_bytes(53, 1, 1, OTHER, -1);
        poll(OTHER);
        drain("R3 overflow cell dropped", 243);

        // R5 single PHY: address held constant
        tx_addr = PORT;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); tx_enb_n = 1'b1; tx_soc = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            send_bytes(53, 1, 1, PORT, -1);
        end
        @(negedge clk); tx_enb_n = 1'b1;
        drain("R5 single phy", 81);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int mode;
            mode = $urandom_range(0, 3);
            case (mode)
                0: begin poll(PORT); send_bytes(53, 1, 1, OTHER, -1); end
                1: begin poll(PORT); send_bytes($urandom_range(1, 52), 1, 1, OTHER, -1);
                         send_bytes(53, 1, 1, OTHER, -1); end
                2: begin poll(OTHER); send_bytes(53, 1, 0, PORT, -1); end
                default: begin poll(PORT); send_bytes($urandom_range(1, 20), 0, 1, PORT, -1); end
            endcase
            poll(OTHER);
            if ($urandom_range(0, 2) == 0) drain("R12 random order", -1);
        end
        drain("R12 random final", -1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule